// File: doc/BRIEF.md
# PCI Target Command Decoder

This block watches a 32-bit multiplexed PCI bus from the target side. It finds the address phase of each transaction and latches the address, the bus command and the configuration select line. It then decides whether the transaction belongs to this device. A claimed transaction has its device-select output driven with medium decode timing, and every completed data phase is passed to a simple back-end port. That port carries the command class, the address of the phase, active-high byte enables, the data word and a one-cycle strobe.

Only eleven command codes are ever claimed, and no reserved code ever is. Memory and I/O commands must also hit one programmable naturally-aligned window. Configuration commands need the select input high in the address phase. Interrupt-acknowledge and special-cycle commands need nothing further. The device-select pad is modelled as a value plus an output enable. The enable is off from reset until the first claim. After the last data phase the pin is driven high for one clock and then released. The block is always ready, so a data phase completes on every clock where the master is ready while device-select is asserted.

Top module: `pci_tgt_decode`

## Requirements
- R1: While `rst` is high and after it, until a claim: `devsel_oe` is 0, `devsel_n_out` is 1, `data_strobe` is 0 and `tgt_cls` is 0.
- R2: An address phase is a clock in which `frame_n_in` is low and the previous clock had both `frame_n_in` and `irdy_n_in` high. A low frame in any other clock starts nothing.
- R3: Command codes on `cbe_n_in` in the address phase map to these `tgt_cls` values: 0000→1 (interrupt ack), 0001→2 (special cycle), 0010→3 (I/O read), 0011→4 (I/O write), 0110→5 (memory read), 0111→6 (memory write), 1010→7 (config read), 1011→8 (config write), 1100→9 (memory read multiple), 1110→10 (memory read line), 1111→11 (memory write and invalidate). Codes 0100, 0101, 1000, 1001 and 1101 are never claimed, and the enable stays off.
- R4: Memory and I/O codes are claimed only when address bits [31:`win_log2`] equal `win_base` bits [31:`win_log2`].
- R5: Configuration codes are claimed only when `cfg_sel_in` is high in the address phase. Interrupt-ack and special-cycle codes are always claimed.
- R6: For a claimed transaction, `devsel_n_out` is low, `devsel_oe` is high and `tgt_cls` holds the class in the second clock after the address phase. They stay so until the final data phase completes.
- R7: A data phase completes at each rising edge where `irdy_n_in` is low and `devsel_n_out` is low. In the following clock, `data_strobe` is 1 for one clock, `tgt_be` equals `~cbe_n_in`, `tgt_wdata` equals `ad_in`, and `tgt_addr` equals the captured address plus 4 times the number of earlier completed phases.
- R8: When the completed phase had `frame_n_in` high, the next clock shows `devsel_n_out` high with `devsel_oe` still high and `tgt_cls` 0. The clock after that shows `devsel_oe` low.
- R9: Edges with `irdy_n_in` high during a claim (wait states) produce no strobe and do not advance the phase address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high bus reset |
| ad_in | input | 32 | Address/data lines as seen by the target |
| cbe_n_in | input | 4 | Command in address phase, active-low byte enables after |
| frame_n_in | input | 1 | Active-low transaction frame |
| irdy_n_in | input | 1 | Active-low master ready |
| cfg_sel_in | input | 1 | Configuration select for this device |
| win_base | input | 32 | Base address of the memory/I/O window |
| win_log2 | input | 5 | Window size as a power of two |
| devsel_n_out | output | 1 | Active-low device-select value |
| devsel_oe | output | 1 | Output enable of the device-select pad |
| tgt_cls | output | 4 | Decoded command class of the claimed transaction, 0 when idle |
| tgt_addr | output | 32 | Address of the phase reported by the strobe |
| tgt_be | output | 4 | Active-high byte enables of that phase |
| tgt_wdata | output | 32 | Data word of that phase |
| data_strobe | output | 1 | One-clock pulse per completed data phase |

## Verification
The bench sends all sixteen command codes with the window hit and the select high, so exactly eleven must be claimed. A decoder with one wrong case arm would claim a reserved code or drop a valid one. Frame going low after a clock where the master was still ready must not count as an address phase; a design that only looks for a falling frame would claim someone else's burst. Wait states between phases check that a design does not strobe or advance the phase address on an edge with the master not ready. Single-phase transactions check the drive-high-then-release order of the pad, which a design that dropped the enable together with the pin would break.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [3:0] {
    CLS_NONE    = 4'd0,
    CLS_INTACK  = 4'd1,
    CLS_SPECIAL = 4'd2,
    CLS_IO_RD   = 4'd3,
    CLS_IO_WR   = 4'd4,
    CLS_MEM_RD  = 4'd5,
    CLS_MEM_WR  = 4'd6,
    CLS_CFG_RD  = 4'd7,
    CLS_CFG_WR  = 4'd8,
    CLS_MEM_RDM = 4'd9,
    CLS_MEM_RDL = 4'd10,
    CLS_MEM_WRI = 4'd11
  } cmd_cls_e;

  // which qualifier a command needs before it is claimed
  typedef enum logic [1:0] {
    QUAL_NEVER,
    QUAL_ALWAYS,
    QUAL_WINDOW,
    QUAL_SELECT
  } qual_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEC,
    ST_CLAIM,
    ST_TURN
  } seq_st_e;

endpackage

// File: rtl/pci_tgt_cmd_lut.sv
module pci_tgt_cmd_lut
  import pci_tgt_pkg::*;
#(
  parameter int CMD_W = 4
) (
  input  logic [CMD_W-1:0] cmd,
  output cmd_cls_e         cls,
  output qual_e            qual
);

  always_comb begin
    cls  = CLS_NONE;
    qual = QUAL_NEVER;
    case (cmd)
      4'b0000: begin cls = CLS_INTACK;  qual = QUAL_ALWAYS; end
      4'b0001: begin cls = CLS_SPECIAL; qual = QUAL_ALWAYS; end
      4'b0010: begin cls = CLS_IO_RD;   qual = QUAL_WINDOW; end
      4'b0011: begin cls = CLS_IO_WR;   qual = QUAL_WINDOW; end
      4'b0110: begin cls = CLS_MEM_RD;  qual = QUAL_WINDOW; end
      4'b0111: begin cls = CLS_MEM_WR;  qual = QUAL_WINDOW; end
      4'b1010: begin cls = CLS_CFG_RD;  qual = QUAL_SELECT; end
      4'b1011: begin cls = CLS_CFG_WR;  qual = QUAL_SELECT; end
      4'b1100: begin cls = CLS_MEM_RDM; qual = QUAL_WINDOW; end
      4'b1110: begin cls = CLS_MEM_RDL; qual = QUAL_WINDOW; end
      4'b1111: begin cls = CLS_MEM_WRI; qual = QUAL_WINDOW; end
      default: begin cls = CLS_NONE;    qual = QUAL_NEVER;  end
    endcase
  end

endmodule

// File: rtl/pci_tgt_win_match.sv
module pci_tgt_win_match #(
  parameter int ADDR_W = 32,
  parameter int LOG_W  = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [LOG_W-1:0]  size_log2,
  output logic              hit
);

  logic [ADDR_W-1:0] miss;

  // a bit takes part in the compare when it lies at or above the window size
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign miss[i] = (i >= int'(size_log2)) && (addr[i] != base[i]);
  end

  assign hit = ~|miss;

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
  import pci_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic claim,
  output logic cap_en,
  output logic decide,
  output logic phase_done,
  output logic ending,
  output logic devsel_n,
  output logic devsel_oe
);

  seq_st_e st_q;
  logic    idle_q;

  assign cap_en     = (st_q == ST_IDLE) && idle_q && !frame_n;
  assign decide     = (st_q == ST_DEC);
  assign phase_done = (st_q == ST_CLAIM) && !irdy_n;
  assign ending     = phase_done && frame_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      idle_q    <= 1'b1;
      devsel_n  <= 1'b1;
      devsel_oe <= 1'b0;
    end else begin
      idle_q <= frame_n & irdy_n;
      case (st_q)
        ST_IDLE: if (cap_en) st_q <= ST_DEC;
        ST_DEC: begin
          if (claim) begin
            st_q      <= ST_CLAIM;
            devsel_n  <= 1'b0;
            devsel_oe <= 1'b1;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        ST_CLAIM: begin
          if (ending) begin
            st_q     <= ST_TURN;
            devsel_n <= 1'b1;
          end
        end
        ST_TURN: begin
          st_q      <= ST_IDLE;
          devsel_oe <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8,
  parameter int LOG_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] ad_in,
  input  logic [BE_W-1:0]   cbe_n_in,
  input  logic              frame_n_in,
  input  logic              irdy_n_in,
  input  logic              cfg_sel_in,
  input  logic [DATA_W-1:0] win_base,
  input  logic [LOG_W-1:0]  win_log2,
  output logic              devsel_n_out,
  output logic              devsel_oe,
  output logic [3:0]        tgt_cls,
  output logic [DATA_W-1:0] tgt_addr,
  output logic [BE_W-1:0]   tgt_be,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic              data_strobe
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(BE_W);

  logic [BE_W-1:0]   cmd_q;
  logic [DATA_W-1:0] addr_q;
  logic              sel_q;
  logic [DATA_W-1:0] cur_addr_q;
  cmd_cls_e          cls_q;

  cmd_cls_e lut_cls;
  qual_e    lut_qual;
  logic     win_hit;
  logic     claim;
  logic     cap_en, decide, phase_done, ending;

  pci_tgt_cmd_lut #(.CMD_W(BE_W)) u_lut (
    .cmd  (cmd_q),
    .cls  (lut_cls),
    .qual (lut_qual)
  );

  pci_tgt_win_match #(.ADDR_W(DATA_W), .LOG_W(LOG_W)) u_win (
    .addr      (addr_q),
    .base      (win_base),
    .size_log2 (win_log2),
    .hit       (win_hit)
  );

  always_comb begin
    case (lut_qual)
      QUAL_ALWAYS: claim = 1'b1;
      QUAL_WINDOW: claim = win_hit;
      QUAL_SELECT: claim = sel_q;
      default:     claim = 1'b0;
    endcase
  end

  pci_tgt_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .frame_n    (frame_n_in),
    .irdy_n     (irdy_n_in),
    .claim      (claim),
    .cap_en     (cap_en),
    .decide     (decide),
    .phase_done (phase_done),
    .ending     (ending),
    .devsel_n   (devsel_n_out),
    .devsel_oe  (devsel_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q       <= '1;
      addr_q      <= '0;
      sel_q       <= 1'b0;
      cur_addr_q  <= '0;
      cls_q       <= CLS_NONE;
      tgt_addr    <= '0;
      tgt_be      <= '0;
      tgt_wdata   <= '0;
      data_strobe <= 1'b0;
    end else begin
      data_strobe <= 1'b0;
      if (cap_en) begin
        cmd_q  <= cbe_n_in;
        addr_q <= ad_in;
        sel_q  <= cfg_sel_in;
      end
      if (decide && claim) begin
        cls_q      <= lut_cls;
        cur_addr_q <= addr_q;
      end
      if (phase_done) begin
        data_strobe <= 1'b1;
        tgt_be      <= ~cbe_n_in;
        tgt_wdata   <= ad_in;
        tgt_addr    <= cur_addr_q;
        cur_addr_q  <= cur_addr_q + STEP;
      end
      if (ending) cls_q <= CLS_NONE;
    end
  end

  assign tgt_cls = cls_q;

endmodule

// File: rtl/pci_tgt_decode_chk.sv
module pci_tgt_decode_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_n_in,
  input logic       irdy_n_in,
  input logic       devsel_n_out,
  input logic       devsel_oe,
  input logic [3:0] tgt_cls,
  input logic       data_strobe
);

  // R6: the pin is never low unless the pad drives it
  a_r6_devsel_driven: assert property (@(posedge clk) disable iff (rst)
    !devsel_n_out |-> devsel_oe);

  // R6: claim lands two clocks after a low frame
  a_r6_medium_timing: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_n_out) |-> ($past(frame_n_in, 2) == 1'b0));

  // R3: a claim always carries a valid class
  a_r3_claim_has_class: assert property (@(posedge clk) disable iff (rst)
    !devsel_n_out |-> (tgt_cls != 4'd0));

  // R7, R9: a strobe follows only an edge with master ready and devsel low
  a_r7_strobe_source: assert property (@(posedge clk) disable iff (rst)
    data_strobe |-> ($past(devsel_n_out) == 1'b0 && $past(irdy_n_in) == 1'b0));

  // R8: the pad is released only after a clock of driving high
  a_r8_release_order: assert property (@(posedge clk) disable iff (rst)
    $fell(devsel_oe) |-> ($past(devsel_n_out) == 1'b1));

  // R1: the enable first turns on together with an asserted pin
  a_r1_enable_on_claim: assert property (@(posedge clk) disable iff (rst)
    $rose(devsel_oe) |-> !devsel_n_out);

endmodule

bind pci_tgt_decode pci_tgt_decode_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .frame_n_in   (frame_n_in),
  .irdy_n_in    (irdy_n_in),
  .devsel_n_out (devsel_n_out),
  .devsel_oe    (devsel_oe),
  .tgt_cls      (tgt_cls),
  .data_strobe  (data_strobe)
);

// File: tb/pci_tgt_decode_tb.sv
`timescale 1ns/1ps
module pci_tgt_decode_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ad_in = '0;
  logic [3:0]  cbe_n_in = '1;
  logic        frame_n_in = 1'b1;
  logic        irdy_n_in = 1'b1;
  logic        cfg_sel_in = 1'b0;
  logic [31:0] win_base = 32'h4000_0000;
  logic [4:0]  win_log2 = 5'd12;
  logic        devsel_n_out, devsel_oe, data_strobe;
  logic [3:0]  tgt_cls, tgt_be;
  logic [31:0] tgt_addr, tgt_wdata;

  int n_run = 0;
  int n_bad = 0;
  int cyc = 0;
  int claims_seen = 0;

  always #2 clk = ~clk;

  pci_tgt_decode u_dut (
    .clk(clk), .rst(rst), .ad_in(ad_in), .cbe_n_in(cbe_n_in),
    .frame_n_in(frame_n_in), .irdy_n_in(irdy_n_in), .cfg_sel_in(cfg_sel_in),
    .win_base(win_base), .win_log2(win_log2),
    .devsel_n_out(devsel_n_out), .devsel_oe(devsel_oe), .tgt_cls(tgt_cls),
    .tgt_addr(tgt_addr), .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
    .data_strobe(data_strobe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [31:0] a);
    return (a >> win_log2) == (win_base >> win_log2);
  endfunction

  function automatic logic [3:0] exp_cls(input logic [3:0] c);
    case (c)
      4'b0000: return 4'd1;  4'b0001: return 4'd2;
      4'b0010: return 4'd3;  4'b0011: return 4'd4;
      4'b0110: return 4'd5;  4'b0111: return 4'd6;
      4'b1010: return 4'd7;  4'b1011: return 4'd8;
      4'b1100: return 4'd9;  4'b1110: return 4'd10;
      4'b1111: return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  function automatic bit exp_claim(input logic [3:0] c, input logic [31:0] a, input bit s);
    case (c)
      4'b0000, 4'b0001: return 1'b1;                               // R5
      4'b1010, 4'b1011: return s;                                  // R5
      4'b0010, 4'b0011, 4'b0110, 4'b0111,
      4'b1100, 4'b1110, 4'b1111: return in_win(a);                 // R4
      default: return 1'b0;                                        // R3
    endcase
  endfunction

  task automatic go_idle(input int n);
    for (int i = 0; i < n; i++) begin
      frame_n_in = 1'b1; irdy_n_in = 1'b1; cbe_n_in = '1;
      @(negedge clk);
    end
  endtask

  // one transaction: address cycle driven at the current negedge
  task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                     input int nph, input int max_wait);
    bit          claimed;
    logic [3:0]  cls_e;
    int          p_drv, w, pdone;
    bit          prev_rdy, prev_last, devlow_prev, ended;
    logic [31:0] dr_ad;
    logic [3:0]  dr_be;
    claimed = exp_claim(cmd, addr, sel);
    cls_e   = exp_cls(cmd);
    frame_n_in = 1'b0; irdy_n_in = 1'b1; ad_in = addr; cbe_n_in = cmd; cfg_sel_in = sel;
    @(negedge clk);
    cfg_sel_in = 1'b0;
    check(devsel_n_out && !data_strobe, "R6", "devsel early", {31'd0, devsel_n_out}, 32'd1);
    p_drv = 0; w = $urandom_range(max_wait, 0); pdone = 0;
    prev_rdy = 0; prev_last = 0; devlow_prev = 0; ended = 0;
    dr_ad = '0; dr_be = '0;
    // phase drive
    if (w > 0) begin irdy_n_in = 1'b1; frame_n_in = 1'b0; w--; prev_rdy = 0; end
    else begin
      dr_ad = $urandom; dr_be = 4'($urandom);
      ad_in = dr_ad; cbe_n_in = ~dr_be; irdy_n_in = 1'b0;
      prev_last = (nph == 1); frame_n_in = prev_last; prev_rdy = 1;
    end
    if (!claimed) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check(!devsel_oe && devsel_n_out, "R3", "unclaimed devsel_oe", {31'd0, devsel_oe}, 32'd0);
        check(tgt_cls == 4'd0 && !data_strobe, "R3", "unclaimed class", {28'd0, tgt_cls}, 32'd0);
        frame_n_in = 1'b0; irdy_n_in = 1'b0;
      end
      go_idle(2);
      return;
    end
    claims_seen++;
    for (int c = 2; !ended && c < 60; c++) begin
      bit done;
      @(negedge clk);
      done = devlow_prev && prev_rdy;
      if (done) begin
        check(data_strobe == 1'b1, "R7", "strobe", {31'd0, data_strobe}, 32'd1);
        check(tgt_be == dr_be, "R7", "byte enables", {28'd0, tgt_be}, {28'd0, dr_be});
        check(tgt_wdata == dr_ad, "R7", "data", tgt_wdata, dr_ad);
        check(tgt_addr == addr + 32'(4 * pdone), "R7", "phase addr", tgt_addr, addr + 32'(4 * pdone));
        pdone++;
        if (prev_last) begin
          check(devsel_n_out && devsel_oe, "R8", "drive high before release",
                {30'd0, devsel_oe, devsel_n_out}, 32'd3);
          check(tgt_cls == 4'd0, "R8", "class cleared", {28'd0, tgt_cls}, 32'd0);
          ended = 1;
        end
      end else begin
        check(data_strobe == 1'b0, "R9", "no strobe on wait", {31'd0, data_strobe}, 32'd0);
      end
      if (!ended) begin
        check(!devsel_n_out && devsel_oe, "R6", "devsel held", {30'd0, devsel_oe, devsel_n_out}, 32'd2);
        check(tgt_cls == cls_e, "R3", "class", {28'd0, tgt_cls}, {28'd0, cls_e});
        devlow_prev = 1;
        if (done) begin p_drv++; w = $urandom_range(max_wait, 0); end
        if (done || !prev_rdy) begin
          if (w > 0) begin irdy_n_in = 1'b1; frame_n_in = 1'b0; w--; prev_rdy = 0; end
          else begin
            dr_ad = $urandom; dr_be = 4'($urandom);
            ad_in = dr_ad; cbe_n_in = ~dr_be; irdy_n_in = 1'b0;
            prev_last = (p_drv == nph - 1); frame_n_in = prev_last; prev_rdy = 1;
          end
        end
      end else begin
        frame_n_in = 1'b1; irdy_n_in = 1'b1; cbe_n_in = '1;
      end
    end
    check(pdone == nph, "R7", "phase count", 32'(pdone), 32'(nph));
    @(negedge clk);
    check(!devsel_oe && devsel_n_out, "R8", "pad released", {31'd0, devsel_oe}, 32'd0);
    check(!data_strobe, "R8", "no strobe after end", {31'd0, data_strobe}, 32'd0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_run++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
      end
    end
  end

  initial begin : stim
    int seed;
    seed = $urandom(32'h1F2E3D4C);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!devsel_oe && devsel_n_out, "R1", "reset devsel", {30'd0, devsel_oe, devsel_n_out}, 32'd1);
    check(!data_strobe && tgt_cls == 0, "R1", "reset outputs", {27'd0, data_strobe, tgt_cls}, 32'd0);
    rst = 1'b0;
    go_idle(3);
    check(!devsel_oe && devsel_n_out, "R1", "idle after reset", {30'd0, devsel_oe, devsel_n_out}, 32'd1);

    // R3: all sixteen codes, window hit and select high
    claims_seen = 0;
    for (int c = 0; c < 16; c++) begin
      txn(4'(c), win_base + 32'h10, 1'b1, 1 + (c % 3), 1);
    end
    check(claims_seen == 11, "R3", "claimed code count", 32'(claims_seen), 32'd11);

    // R4: window miss for memory and I/O
    txn(4'b0111, win_base ^ 32'h8000_0000, 1'b1, 1, 0);
    txn(4'b0010, win_base + (32'h1 << win_log2), 1'b1, 1, 0);
    // R5: config without select, int-ack outside window
    txn(4'b1010, win_base, 1'b0, 1, 0);
    txn(4'b0000, 32'hDEAD_BEE0, 1'b0, 2, 0);

    // R2: frame low after a clock with the master still ready is not an address phase
    frame_n_in = 1'b1; irdy_n_in = 1'b0; @(negedge clk);
    frame_n_in = 1'b0; ad_in = win_base; cbe_n_in = 4'b0111; irdy_n_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(!devsel_oe, "R2", "no claim without idle clock", {31'd0, devsel_oe}, 32'd0);
      irdy_n_in = 1'b0;
    end
    go_idle(2);

    // R7, R9: long bursts with wait states
    txn(4'b1110, win_base + 32'h40, 1'b0, 4, 3);
    txn(4'b0111, win_base + 32'hFFC, 1'b0, 3, 2);

    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [3:0]  c;
      logic [31:0] a;
      if (t % 50 == 0) begin
        win_log2 = 5'($urandom_range(20, 4));
        win_base = $urandom;
      end
      c = 4'($urandom);
      a = ($urandom_range(9, 0) < 6) ? (win_base ^ ($urandom & ((32'h1 << win_log2) - 1))) : $urandom;
      txn(c, a, 1'($urandom), $urandom_range(4, 1), $urandom_range(2, 0));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule